// File: doc/BRIEF.md
# Pseudo-Cause Interrupt Aggregator

This block is the top summary stage of a three-group interrupt tree. The receive, transmit and miscellaneous groups each present one level that is already the OR of that group's pending, unmasked causes. The aggregator latches each level into one bit of a 32-bit summary register. The summary register clears when the host reads it, so no acknowledge write is needed. A separate software mask register then gates the summary bits onto one level-high host interrupt line.

A host handler reads the summary register first. A value of zero tells the handler that the interrupt came from elsewhere. A low byte of 0xFF is treated as a dead bus and is never produced here. The handler then services the groups it found. While it works it can hold the line off by writing all ones to the mask. Writing a mask whose low three bits are zero enables all three groups again.

Top module: `pseudo_cause_aggr`

## Requirements
- R1: After reset the summary reads zero, the mask reads all ones (0xFFFFFFFF) and the host line is low.
- R2: A group input that is high at a clock edge sets its summary bit from that edge on. Receive is bit 0, transmit is bit 1 and miscellaneous is bit 2. The bit stays set after the input drops, until the summary is read.
- R3: A read strobe at an edge clears every summary bit whose input is low at that edge.
- R4: A group input that is high at the same edge as a read leaves its summary bit set after that edge, so an event is never lost to a read.
- R5: Summary bits 31 to 3 always read zero, so the low byte of the summary can never be 0xFF.
- R6: The host line is high exactly when some summary bit is set and its mask bit (same position) is zero.
- R7: A mask write takes effect at the clock edge where it is strobed. Writing all ones holds the line low whatever the summary holds. Writing zeros in bits 2 to 0 enables all three groups.
- R8: All 32 mask bits are stored and read back, but bits 31 to 3 have no effect on the host line.
- R9: Masking a group does not stop its events from being latched into the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_irq_i | input | 3 | Group levels: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| sum_rd_i | input | 1 | Summary read strobe; clears the summary at the edge |
| sum_rdata_o | output | 32 | Summary register contents |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 32 | Mask write data; a 1 blocks that bit |
| mask_rdata_o | output | 32 | Mask register contents |
| irq_o | output | 1 | Host interrupt line, level high |

## Verification
A summary bit that is stuck or cleared at the wrong moment shows up on sum_rdata_o in the cycle right after the edge concerned. If it is lost during a read, it shows up as a zero where the event should have left a one. A mask bit that is stored wrongly shows on mask_rdata_o after the write edge. A mask bit that is decoded at the wrong position shows on irq_o in that same cycle. Held inputs mixed with read strobes expose the read/set race. The bench checks every output after every edge, so any such fault is visible within one clock.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
  localparam int NUM_GRP  = 3;
  localparam int REG_W    = 32;
  // summary bit positions decoded by host software
  localparam int IDX_RX   = 0;
  localparam int IDX_TX   = 1;
  localparam int IDX_MISC = 2;
endpackage

// File: rtl/pc_cause_bit.sv
`timescale 1ns/1ps
module pc_cause_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set wins over clear so an event coincident with a read survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= (q_q & ~clr_i) | set_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pc_mask_reg.sv
`timescale 1ns/1ps
module pc_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '1;
    else if (we_i) q_q <= wdata_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pc_line_gate.sv
`timescale 1ns/1ps
module pc_line_gate #(
  parameter int NUM_GRP = 3
) (
  input  logic [NUM_GRP-1:0] sum_i,
  input  logic [NUM_GRP-1:0] mask_i,
  output logic               irq_o
);
  assign irq_o = |(sum_i & ~mask_i);
endmodule

// File: rtl/pseudo_cause_aggr.sv
`timescale 1ns/1ps
module pseudo_cause_aggr
  import pc_pkg::*;
#(
  parameter int NGRP   = NUM_GRP,
  parameter int DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NGRP-1:0]   grp_irq_i,
  input  logic              sum_rd_i,
  output logic [DATA_W-1:0] sum_rdata_o,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [DATA_W-1:0] mask_rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NGRP;

  logic [NGRP-1:0]   sum;
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < NGRP; g++) begin : g_cause
    pc_cause_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (grp_irq_i[g]),
      .clr_i (sum_rd_i),
      .q_o   (sum[g])
    );
  end

  pc_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we_i),
    .wdata_i(mask_wdata_i),
    .q_o    (mask)
  );

  // only the group positions gate the line
  pc_line_gate #(.NUM_GRP(NGRP)) u_gate (
    .sum_i (sum),
    .mask_i(mask[NGRP-1:0]),
    .irq_o (irq_o)
  );

  assign sum_rdata_o  = {{PAD_W{1'b0}}, sum};
  assign mask_rdata_o = mask;
endmodule

// File: rtl/pc_aggr_chk.sv
`timescale 1ns/1ps
module pc_aggr_chk #(
  parameter int NGRP   = 3,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NGRP-1:0]   grp_irq_i,
  input logic              sum_rd_i,
  input logic [DATA_W-1:0] sum_rdata_o,
  input logic              mask_we_i,
  input logic [DATA_W-1:0] mask_wdata_i,
  input logic [DATA_W-1:0] mask_rdata_o,
  input logic              irq_o
);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_irq_i != '0) |=> ((sum_rdata_o[NGRP-1:0] & $past(grp_irq_i)) == $past(grp_irq_i)));

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sum_rd_i && grp_irq_i == '0) |=> $stable(sum_rdata_o));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_rd_i && grp_irq_i == '0) |=> (sum_rdata_o == '0));

  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_rd_i |=> (sum_rdata_o[NGRP-1:0] == $past(grp_irq_i)));

  p_no_ff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_rdata_o[DATA_W-1:NGRP] == '0) && (sum_rdata_o[7:0] != 8'hff));

  p_line_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sum_rdata_o != '0));

  p_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && (&mask_wdata_i[NGRP-1:0])) |=> !irq_o);

  p_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_rdata_o == $past(mask_wdata_i)));
endmodule

bind pseudo_cause_aggr pc_aggr_chk #(.NGRP(NGRP), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grp_irq_i   (grp_irq_i),
  .sum_rd_i    (sum_rd_i),
  .sum_rdata_o (sum_rdata_o),
  .mask_we_i   (mask_we_i),
  .mask_wdata_i(mask_wdata_i),
  .mask_rdata_o(mask_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/pseudo_cause_aggr_tb.sv
`timescale 1ns/1ps
module pseudo_cause_aggr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  grp_irq_i = '0;
  logic        sum_rd_i = 1'b0;
  logic        mask_we_i = 1'b0;
  logic [31:0] mask_wdata_i = '0;
  logic [31:0] sum_rdata_o, mask_rdata_o;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0]  m_sum  = '0;
  logic [31:0] m_mask = '1;

  always #4 clk_i = ~clk_i;

  pseudo_cause_aggr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .grp_irq_i(grp_irq_i), .sum_rd_i(sum_rd_i),
    .sum_rdata_o(sum_rdata_o), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .mask_rdata_o(mask_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [2:0] f_sum(logic [2:0] s, logic [2:0] g, logic rd);
    return (rd ? 3'b000 : s) | g;
  endfunction

  function automatic logic f_irq(logic [2:0] s, logic [31:0] m);
    return |(s & ~m[2:0]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2/R3/R4 summary"}, sum_rdata_o, {29'd0, m_sum});
    chk("R5 upper zero", {31'd0, (sum_rdata_o[31:3] == '0) && (sum_rdata_o[7:0] != 8'hff)}, 32'd1);
    chk({tag, " R6 line"}, {31'd0, irq_o}, {31'd0, f_irq(m_sum, m_mask)});
    chk({tag, " R8 mask readback"}, mask_rdata_o, m_mask);
  endtask

  // drive at negedge, model at posedge, check at next negedge
  task automatic step(logic [2:0] g, logic rd, logic we, logic [31:0] wd, string tag);
    grp_irq_i = g; sum_rd_i = rd; mask_we_i = we; mask_wdata_i = wd;
    @(posedge clk_i);
    m_sum = f_sum(m_sum, g, rd);
    if (we) m_mask = wd;
    @(negedge clk_i);
    check_all(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R1 summary zero", sum_rdata_o, 32'd0);
    chk("R1 mask ones", mask_rdata_o, 32'hffff_ffff);
    chk("R1 line low", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    step(3'b010, 0, 0, '0, "R9 masked tx latched");
    chk("R9 tx bit", sum_rdata_o, 32'h2);
    chk("R7 all-ones mask blocks", {31'd0, irq_o}, 32'd0);
    step(3'b000, 0, 0, '0, "R2 sticky");
    chk("R2 sticky tx", sum_rdata_o, 32'h2);
    step(3'b000, 1, 0, '0, "R3 read clears");
    chk("R3 cleared", sum_rdata_o, 32'h0);
    step(3'b100, 0, 0, '0, "R2 misc set");
    step(3'b100, 1, 0, '0, "R4 held during read");
    chk("R4 misc kept", sum_rdata_o, 32'h4);
    step(3'b000, 0, 1, 32'hffff_fff8, "R7 enable all");
    chk("R7 line high", {31'd0, irq_o}, 32'd1);
    step(3'b000, 0, 1, 32'h0000_0004, "R6 misc masked");
    chk("R6 line low misc masked", {31'd0, irq_o}, 32'd0);
    step(3'b001, 0, 0, '0, "R6 rx unmasked");
    chk("R6 line high rx", {31'd0, irq_o}, 32'd1);
    step(3'b000, 1, 1, 32'h0000_0007, "R8 upper zeros low ones");
    step(3'b111, 0, 0, '0, "R8 no effect upper");
    chk("R8 line low", {31'd0, irq_o}, 32'd0);
    chk("R5 all groups", sum_rdata_o, 32'h7);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] wd;
      logic [2:0]  g;
      g  = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      wd = $urandom;
      case ($urandom_range(0, 3))
        0: wd = 32'hffff_ffff;
        1: wd = 32'hffff_fff8;
        default: ;
      endcase
      step(g, ($urandom_range(0, 2) == 0), ($urandom_range(0, 7) == 0), wd, "rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule